// File: doc/BRIEF.md
# Control Endpoint IN-Stage Controller

This block runs the device-to-host data phase of control endpoint zero. Once firmware has decoded a setup request and chosen the device-to-host direction, it fills a single-packet transmit buffer one byte at a time. It then fires an arm strobe to mark the buffer ready. Each IN token from the host gets one of two answers. If a packet is armed, the block streams it out: a start pulse carrying the length, then the bytes on consecutive cycles. If nothing is armed, the block refuses with a NAK pulse.

The packet stays armed until the host returns ACK. At that point the buffer is released, a sticky completion flag is set and an interrupt is raised if enabled. Firmware ends a reply in one of two ways. If the reply is shorter than the host asked for, the last packet is shorter than the maximum packet size. If the reply is an exact multiple of that size, firmware arms an empty packet.

An OUT token from the host closes the data phase and moves the block into the status phase. A setup token clears everything and aborts any transfer in flight. Tokens and handshakes arrive as single-cycle strobes that have already been decoded. Line coding and CRC are handled elsewhere.

Top module: `ep0_in_ctrl`

## Requirements
- R1: While unarmed, each `fw_wr_en` pulse appends one byte to the buffer and increments `byte_cnt`. An IN token in the data phase with a packet armed gives `tx_start` one cycle later, with `tx_len` equal to the byte count. The bytes follow in write order, one per cycle on `tx_valid` starting the cycle after `tx_start`, and `tx_last` is high with the final byte.
- R2: An IN token in the data phase with no packet armed gives a one-cycle `nak` pulse one cycle later, and no `tx_start` or `tx_valid`.
- R3: `hs_ack` while the block is waiting for a handshake sets `done_flag` on the next cycle, raises `irq` if `fw_irq_en` is high, resets `byte_cnt` to 0 and disarms the buffer, so the next IN token is NAKed.
- R4: `done_flag` stays set until `fw_clr_done` is pulsed. `irq` equals `done_flag` AND `fw_irq_en`, registered one cycle later.
- R5: Any packet length from 1 up to `MAX_PKT` (default 64) bytes is sent intact.
- R6: Arming with zero bytes written sends a zero-length packet: `tx_start` with `tx_len`=0 and no `tx_valid` cycle.
- R7: If no ACK arrives, the packet stays armed, and the next IN token resends the identical packet.
- R8: An OUT token in the data phase moves `stage` to 2 (status). In the status phase, IN tokens are NAKed.
- R9: A setup token moves `stage` to 0 (idle), empties the buffer (`byte_cnt`=0), disarms it and stops any transmission from the next cycle on.
- R10: A write while a packet is armed, or while the buffer already holds `MAX_PKT` bytes, leaves the buffer unchanged and sets the sticky `ovf_err`. `fw_clr_err` clears `ovf_err`.
- R11: After reset, `stage`=0, `byte_cnt`=0, and `done_flag`, `irq`, `ovf_err`, `nak`, `tx_start` and `tx_valid` are all 0.
- R12: `fw_start_in` moves `stage` from 0 (idle) to 1 (data phase) and has no effect in other stages. IN tokens outside the data phase are NAKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | DATA_W | Byte to append to the packet |
| fw_arm | input | 1 | Mark the buffered packet ready to send |
| fw_start_in | input | 1 | Firmware selects the device-to-host data phase |
| fw_clr_done | input | 1 | Clear the completion flag |
| fw_clr_err | input | 1 | Clear the overflow error flag |
| fw_irq_en | input | 1 | Completion interrupt enable |
| tok_setup | input | 1 | Decoded setup token strobe |
| tok_in | input | 1 | Decoded IN token strobe |
| tok_out | input | 1 | Decoded OUT token strobe |
| hs_ack | input | 1 | Host ACK handshake strobe |
| tx_start | output | 1 | Packet start pulse |
| tx_len | output | CNT_W | Length of the packet being sent |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | DATA_W | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| nak | output | 1 | NAK reply pulse |
| stage | output | 2 | 0 idle, 1 data phase, 2 status phase |
| byte_cnt | output | CNT_W | Bytes currently buffered |
| done_flag | output | 1 | Sticky transmit-complete flag |
| irq | output | 1 | Completion interrupt |
| ovf_err | output | 1 | Sticky write overflow error |

## Verification
The bench checks the full-size packet and the empty packet. A design off by one in its read pointer would drop or repeat a byte, or send a byte for the empty packet. It holds back the ACK to confirm the same packet goes out again, because a design that disarmed the buffer on send would NAK instead. It writes into an armed buffer and into a full one, since a missing guard would corrupt the packet that goes out. It fires a setup token in the middle of a packet, where a design that did not abort would keep `tx_valid` high.

// File: rtl/ep0_in_pkg.sv
package ep0_in_pkg;
  typedef enum logic [1:0] {
    STG_IDLE    = 2'd0,
    STG_DATA_IN = 2'd1,
    STG_STATUS  = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } txst_e;
endpackage

// File: rtl/ep0_pkt_buf.sv
module ep0_pkt_buf #(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int CNT_W  = $clog2(MAX_PKT + 1),
  localparam int ADDR_W = $clog2(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              arm,
  input  logic              flush,
  input  logic              clr_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              valid,
  output logic              ovf
);
  logic [DATA_W-1:0] mem [MAX_PKT];
  logic              full;
  logic              wr_ok;

  assign full  = (count == CNT_W'(MAX_PKT));
  assign wr_ok = wr_en && !valid && !full && !flush;

  // storage with one write and one registered read port
  always_ff @(posedge clk) begin
    if (wr_ok) mem[count[ADDR_W-1:0]] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      valid <= 1'b0;
    end else if (flush) begin
      count <= '0;
      valid <= 1'b0;
    end else begin
      if (wr_ok) count <= count + CNT_W'(1);
      if (arm)   valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (wr_en && !wr_ok && !flush) ovf <= 1'b1;
    else if (clr_err) ovf <= 1'b0;
  end

  // R10
  armed_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && valid && !flush) |=> (count == $past(count)) && ovf);

  // R10
  full_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !flush) |=> (count == CNT_W'(MAX_PKT)) && ovf);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0) && !valid);
endmodule

// File: rtl/ep0_stage_ctl.sv
module ep0_stage_ctl
  import ep0_in_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tok_setup,
  input  logic   tok_out,
  input  logic   fw_start_in,
  output stage_e stage
);
  always_ff @(posedge clk) begin
    if (rst || tok_setup) begin
      stage <= STG_IDLE;
    end else begin
      case (stage)
        STG_IDLE:    if (fw_start_in) stage <= STG_DATA_IN;
        STG_DATA_IN: if (tok_out)     stage <= STG_STATUS;
        default:     stage <= stage;
      endcase
    end
  end

  // R9
  setup_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tok_setup |=> stage == STG_IDLE);

  // R8
  out_to_status_chk: assert property (@(posedge clk) disable iff (rst)
    (stage == STG_DATA_IN && tok_out && !tok_setup) |=> stage == STG_STATUS);

  // R12
  start_in_chk: assert property (@(posedge clk) disable iff (rst)
    (stage == STG_IDLE && fw_start_in && !tok_setup) |=> stage == STG_DATA_IN);
endmodule

// File: rtl/ep0_tx_engine.sv
module ep0_tx_engine
  import ep0_in_pkg::*;
#(
  parameter int MAX_PKT = 64,
  localparam int CNT_W  = $clog2(MAX_PKT + 1),
  localparam int ADDR_W = $clog2(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_stage,
  input  logic              tok_in,
  input  logic              hs_ack,
  input  logic              abort,
  input  logic              irq_en,
  input  logic              clr_done,
  input  logic              pkt_valid,
  input  logic [CNT_W-1:0]  pkt_len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pkt_done,
  output logic              tx_start,
  output logic [CNT_W-1:0]  tx_len,
  output logic              tx_valid,
  output logic              tx_last,
  output logic              nak,
  output logic              done,
  output logic              irq
);
  txst_e            state;
  logic [CNT_W-1:0] ptr;
  logic [CNT_W-1:0] ptr_nxt;
  logic             live;
  logic             start_go;
  logic             nak_go;
  logic             done_nxt;

  assign live     = in_stage && !abort;
  assign ptr_nxt  = ptr + CNT_W'(1);
  assign rd_en    = live && (state == TX_SEND) && (ptr != pkt_len);
  assign rd_addr  = ptr[ADDR_W-1:0];
  assign pkt_done = live && (state == TX_WAIT) && hs_ack;
  assign start_go = live && tok_in && pkt_valid && (state != TX_SEND) && !pkt_done;
  assign nak_go   = tok_in && !abort && (!in_stage || (!pkt_valid && state != TX_SEND));
  assign done_nxt = pkt_done ? 1'b1 : (clr_done ? 1'b0 : done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      ptr   <= '0;
    end else if (!live) begin
      state <= TX_IDLE;
      ptr   <= '0;
    end else begin
      case (state)
        TX_IDLE: if (start_go) begin
          state <= TX_SEND;
          ptr   <= '0;
        end
        TX_SEND: if (ptr == pkt_len) state <= TX_WAIT;
                 else ptr <= ptr_nxt;
        TX_WAIT: if (pkt_done) begin
          state <= TX_IDLE;
        end else if (start_go) begin
          state <= TX_SEND;
          ptr   <= '0;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start <= 1'b0;
      tx_len   <= '0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      nak      <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      tx_start <= start_go;
      if (start_go) tx_len <= pkt_len;
      tx_valid <= rd_en;
      tx_last  <= rd_en && (ptr_nxt == pkt_len);
      nak      <= nak_go;
      done     <= done_nxt;
      irq      <= done_nxt && irq_en;
    end
  end

  // R2
  nak_excl_start_chk: assert property (@(posedge clk) disable iff (rst)
    !(nak && tx_start));

  // R1
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  // R3
  ack_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_WAIT && hs_ack && live) |=> done && !pkt_valid);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !clr_done) |=> done);

  // R7
  resend_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_WAIT && tok_in && !hs_ack && live) |=> tx_start);
endmodule

// File: rtl/ep0_in_ctrl.sv
module ep0_in_ctrl
  import ep0_in_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int CNT_W  = $clog2(MAX_PKT + 1),
  localparam int ADDR_W = $clog2(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fw_wr_en,
  input  logic [DATA_W-1:0] fw_wr_data,
  input  logic              fw_arm,
  input  logic              fw_start_in,
  input  logic              fw_clr_done,
  input  logic              fw_clr_err,
  input  logic              fw_irq_en,
  input  logic              tok_setup,
  input  logic              tok_in,
  input  logic              tok_out,
  input  logic              hs_ack,
  output logic              tx_start,
  output logic [CNT_W-1:0]  tx_len,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              nak,
  output logic [1:0]        stage,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              done_flag,
  output logic              irq,
  output logic              ovf_err
);
  stage_e            stg;
  logic              pkt_valid;
  logic              pkt_done;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              flush;

  assign flush = tok_setup || pkt_done;
  assign stage = stg;

  ep0_stage_ctl u_stage (
    .clk         (clk),
    .rst         (rst),
    .tok_setup   (tok_setup),
    .tok_out     (tok_out),
    .fw_start_in (fw_start_in),
    .stage       (stg)
  );

  ep0_pkt_buf #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fw_wr_en),
    .wr_data (fw_wr_data),
    .arm     (fw_arm),
    .flush   (flush),
    .clr_err (fw_clr_err),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (tx_data),
    .count   (byte_cnt),
    .valid   (pkt_valid),
    .ovf     (ovf_err)
  );

  ep0_tx_engine #(.MAX_PKT(MAX_PKT)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .in_stage  (stg == STG_DATA_IN),
    .tok_in    (tok_in),
    .hs_ack    (hs_ack),
    .abort     (tok_setup),
    .irq_en    (fw_irq_en),
    .clr_done  (fw_clr_done),
    .pkt_valid (pkt_valid),
    .pkt_len   (byte_cnt),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .pkt_done  (pkt_done),
    .tx_start  (tx_start),
    .tx_len    (tx_len),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .nak       (nak),
    .done      (done_flag),
    .irq       (irq)
  );

  // R12
  in_outside_stage_nak_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_in && !tok_setup && stg != STG_DATA_IN) |=> nak && !tx_start);
endmodule

// File: tb/ep0_in_ctrl_test.sv
`timescale 1ns/1ps
module ep0_in_ctrl_test;
  localparam int MAXP = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fw_wr_en = 0, fw_arm = 0, fw_start_in = 0;
  logic       fw_clr_done = 0, fw_clr_err = 0, fw_irq_en = 0;
  logic [7:0] fw_wr_data = 0;
  logic       tok_setup = 0, tok_in = 0, tok_out = 0, hs_ack = 0;
  logic       tx_start, tx_valid, tx_last, nak, done_flag, irq, ovf_err;
  logic [6:0] tx_len, byte_cnt;
  logic [7:0] tx_data;
  logic [1:0] stage;

  int total = 0, bad = 0;
  int cyc = 0, starts = 0, naks = 0, st_len = 0, st_cyc = 0, lst_cyc = -1, cap_n = 0;
  logic [7:0] cap [128];

  always #5 clk = ~clk;

  ep0_in_ctrl uut (
    .clk(clk), .rst(rst), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
    .fw_arm(fw_arm), .fw_start_in(fw_start_in), .fw_clr_done(fw_clr_done),
    .fw_clr_err(fw_clr_err), .fw_irq_en(fw_irq_en), .tok_setup(tok_setup),
    .tok_in(tok_in), .tok_out(tok_out), .hs_ack(hs_ack), .tx_start(tx_start),
    .tx_len(tx_len), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .nak(nak), .stage(stage), .byte_cnt(byte_cnt), .done_flag(done_flag),
    .irq(irq), .ovf_err(ovf_err)
  );

  // output monitor, samples between clock edges
  always @(negedge clk) begin
    cyc++;
    if (tx_start) begin
      starts++; st_len = int'(tx_len); st_cyc = cyc; cap_n = 0; lst_cyc = -1;
    end
    if (tx_valid) begin
      if (cap_n < 128) cap[cap_n] = tx_data;
      cap_n++;
      if (tx_last) lst_cyc = cyc;
    end
    if (nak) naks++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic write_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fw_wr_en = 1; fw_wr_data = 8'((i * 7 + seed) & 255);
    end
    @(negedge clk); fw_wr_en = 0;
  endtask

  task automatic pulse_arm();     @(negedge clk); fw_arm = 1;      @(negedge clk); fw_arm = 0;      endtask
  task automatic pulse_start();   @(negedge clk); fw_start_in = 1; @(negedge clk); fw_start_in = 0; endtask
  task automatic pulse_clr();     @(negedge clk); fw_clr_done = 1; @(negedge clk); fw_clr_done = 0; endtask
  task automatic pulse_clr_err(); @(negedge clk); fw_clr_err = 1;  @(negedge clk); fw_clr_err = 0;  endtask
  task automatic pulse_ack();     @(negedge clk); hs_ack = 1;      @(negedge clk); hs_ack = 0;      endtask
  task automatic pulse_setup();   @(negedge clk); tok_setup = 1;   @(negedge clk); tok_setup = 0;   endtask
  task automatic pulse_out();     @(negedge clk); tok_out = 1;     @(negedge clk); tok_out = 0;     endtask
  task automatic pulse_in();      @(negedge clk); tok_in = 1;      @(negedge clk); tok_in = 0;      endtask

  // send an IN token and check the whole packet against the expected pattern
  task automatic in_expect_pkt(input string req, input int len, input int seed);
    int s0, n0, errs;
    s0 = starts; n0 = naks; errs = 0;
    pulse_in();
    cyc_wait(len + 3);
    chk({req, " start"}, starts - s0, 1);
    chk({req, " no nak"}, naks - n0, 0);
    chk({req, " len"}, st_len, len);
    chk({req, " bytes"}, cap_n, len);
    for (int i = 0; i < len; i++)
      if (cap[i] !== 8'((i * 7 + seed) & 255)) errs++;
    chk({req, " data errs"}, errs, 0);
    if (len > 0) chk({req, " last timing"}, lst_cyc - st_cyc, len);
    else         chk({req, " no last"}, lst_cyc, -1);
  endtask

  task automatic in_expect_nak(input string req);
    int s0, n0;
    s0 = starts; n0 = naks;
    pulse_in();
    cyc_wait(3);
    chk({req, " nak"}, naks - n0, 1);
    chk({req, " no start"}, starts - s0, 0);
  endtask

  task automatic t_reset();
    cyc_wait(1);
    chk("R11 stage", int'(stage), 0);
    chk("R11 count", int'(byte_cnt), 0);
    chk("R11 flags", {done_flag, irq, ovf_err, nak, tx_start, tx_valid}, 0);
  endtask

  task automatic t_stage_select();
    in_expect_nak("R12 idle");
    pulse_start(); cyc_wait(1);
    chk("R12 data stage", int'(stage), 1);
  endtask

  task automatic t_nak_empty();
    in_expect_nak("R2 empty");
  endtask

  task automatic t_short_retx_ack();
    fw_irq_en = 1;
    write_bytes(5, 3); cyc_wait(1);
    chk("R1 count", int'(byte_cnt), 5);
    pulse_arm();
    in_expect_pkt("R1 R5 short", 5, 3);
    chk("R7 no done yet", int'(done_flag), 0);
    in_expect_pkt("R7 resend", 5, 3);
    pulse_ack(); cyc_wait(1);
    chk("R3 done", int'(done_flag), 1);
    chk("R3 irq", int'(irq), 1);
    chk("R3 count", int'(byte_cnt), 0);
    in_expect_nak("R3 disarmed");
  endtask

  task automatic t_done_sticky();
    cyc_wait(5);
    chk("R4 sticky", int'(done_flag), 1);
    pulse_clr(); cyc_wait(1);
    chk("R4 cleared", int'(done_flag), 0);
    chk("R4 irq cleared", int'(irq), 0);
    fw_irq_en = 0;
    write_bytes(2, 9); pulse_arm();
    in_expect_pkt("R4 pkt", 2, 9);
    pulse_ack(); cyc_wait(1);
    chk("R4 done masked", int'(done_flag), 1);
    chk("R4 irq masked", int'(irq), 0);
    @(negedge clk); fw_irq_en = 1; cyc_wait(1);
    chk("R4 irq follows en", int'(irq), 1);
    pulse_clr(); cyc_wait(1);
  endtask

  task automatic t_full_overflow();
    write_bytes(MAXP, 11); cyc_wait(1);
    chk("R5 full count", int'(byte_cnt), MAXP);
    chk("R10 no ovf yet", int'(ovf_err), 0);
    @(negedge clk); fw_wr_en = 1; fw_wr_data = 8'hEE; @(negedge clk); fw_wr_en = 0; cyc_wait(1);
    chk("R10 full ovf", int'(ovf_err), 1);
    chk("R10 full count", int'(byte_cnt), MAXP);
    pulse_clr_err(); cyc_wait(1);
    chk("R10 err cleared", int'(ovf_err), 0);
    pulse_arm();
    @(negedge clk); fw_wr_en = 1; fw_wr_data = 8'h55; @(negedge clk); fw_wr_en = 0; cyc_wait(1);
    chk("R10 armed ovf", int'(ovf_err), 1);
    chk("R10 armed count", int'(byte_cnt), MAXP);
    in_expect_pkt("R5 R10 full pkt", MAXP, 11);
    pulse_ack(); pulse_clr(); pulse_clr_err(); cyc_wait(1);
  endtask

  task automatic t_zlp();
    pulse_arm();
    in_expect_pkt("R6 zlp", 0, 0);
    pulse_ack(); cyc_wait(1);
    chk("R6 done", int'(done_flag), 1);
    pulse_clr();
  endtask

  task automatic t_out_status();
    pulse_out(); cyc_wait(1);
    chk("R8 status", int'(stage), 2);
    in_expect_nak("R8 status in");
    pulse_start(); cyc_wait(1);
    chk("R12 start ignored", int'(stage), 2);
  endtask

  task automatic t_setup_abort();
    pulse_setup(); cyc_wait(1);
    chk("R9 idle", int'(stage), 0);
    pulse_start();
    write_bytes(10, 5); pulse_arm();
    pulse_in();
    cyc_wait(2);
    chk("R9 sending", int'(tx_valid), 1);
    @(negedge clk); tok_setup = 1; @(negedge clk); tok_setup = 0; #1;
    chk("R9 stopped", int'(tx_valid), 0);
    chk("R9 stage", int'(stage), 0);
    chk("R9 count", int'(byte_cnt), 0);
    cyc_wait(2);
    chk("R9 still quiet", int'(tx_valid), 0);
    pulse_start();
    in_expect_nak("R9 disarmed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_stage_select();
    t_nak_empty();
    t_short_retx_ack();
    t_done_sticky();
    t_full_overflow();
    t_zlp();
    t_out_status();
    t_setup_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule